// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

The block computes X^E mod M for an odd modulus M by right-to-left binary exponentiation built on radix-2 Montgomery multiplication. It holds one shared multiplier operand register B and two operand registers, P (the running product) and Z (the running power). On each exponent bit it runs two bit-serial Montgomery multipliers in parallel. One squares Z. The other multiplies P by Z, and its result is kept only when that exponent bit is 1. The squaring result is written back to Z and also to B, so B serves as the common second operand of both products in the next step. Each multiplier takes its first operand one bit per cycle, least significant bit first.

A caller presents the base, the exponent, the modulus and the constant R² mod M, where R = 2^(WIDTH+2), and pulses a start strobe. The first step multiplies P = 1 and Z = X by B = R² mod M, which brings both values into Montgomery form. After the last exponent bit, B is set to 1 and one more multiplication takes P out of Montgomery form. Intermediate values are never reduced below M. They stay below 2M, and a single conditional subtraction of M is applied just before the result is presented together with a one-cycle done strobe.

Top module: `mont_exp`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and result_o is 0.
- R2: For an odd modulus 3 <= m_i < 2^WIDTH, a base x_i < m_i and r2_i = 2^(2*(WIDTH+2)) mod m_i, the result_o presented with done_o equals x_i^e_i mod m_i.
- R3: With e_i = 0 the result is 1.
- R4: With e_i = 1 the result equals x_i.
- R5: Whenever done_o is 1, result_o is below the modulus of that run.
- R6: busy_o rises in the cycle after start_i is accepted and stays 1 until the cycle in which done_o is 1, where it is 0. done_o is high for exactly one cycle.
- R7: A start_i pulse while busy_o is 1 is ignored: the running computation finishes with the result for the operands it was started with.
- R8: While busy_o is 0, result_o keeps its value until a later run completes.
- R9: The number of cycles from start to done_o is the same for every operand set, including every exponent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when busy_o is 0 |
| x_i | input | WIDTH | Base, below the modulus |
| e_i | input | EXP_W | Exponent |
| m_i | input | WIDTH | Odd modulus |
| r2_i | input | WIDTH | 2^(2*(WIDTH+2)) mod m_i |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle strobe, result_o valid |
| result_o | output | WIDTH | x_i^e_i mod m_i, held until the next completion |

## Verification
The hardest case to reach from the ports is an unreduced operand: a Montgomery product that lands between M and 2M and is fed into the next step without correction, and in particular a final value that still needs the closing subtraction. Such values show up only for some pairs of modulus and base. The bench therefore sweeps every odd modulus of the 8-bit configuration. For each modulus it uses exponents 0, 1 and all ones, the bases 0 and m-1, and pseudo-random pairs, so that the deferred-reduction paths are exercised many times. The run time is identical for every operand set, so a separate run pulses start mid-computation with different operands and checks that this pulse has no effect.

// File: rtl/mont_exp_pkg.sv
package mont_exp_pkg;
  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,  // enter Montgomery form
    PH_BIT  = 2'd1,  // one exponent bit
    PH_POST = 2'd2,  // leave Montgomery form
    PH_SUB  = 2'd3   // final conditional subtraction
  } phase_e;
endpackage

// File: rtl/mont_mul_serial.sv
// Radix-2 Montgomery product, one multiplier bit per cycle, LSB first.
// Result is a*b*2^-ITER mod n, below 2n for a, b < 2n.
module mont_mul_serial #(
  parameter int OW   = 9,
  parameter int ITER = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [OW-1:0] a_i,
  input  logic [OW-1:0] b_i,
  input  logic [OW-1:0] n_i,
  output logic          done_o,
  output logic [OW-1:0] p_o
);
  localparam int AW   = OW + 2;
  localparam int CNTW = $clog2(ITER + 1);

  logic [AW-1:0]   acc_q, sum_a, sum_n;
  logic [OW-1:0]   a_sh_q;
  logic [CNTW-1:0] cnt_q;
  logic            done_q;

  always_comb begin
    sum_a = acc_q + (a_sh_q[0] ? {2'b00, b_i} : '0);
    sum_n = sum_a + (sum_a[0] ? {2'b00, n_i} : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      a_sh_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        acc_q  <= '0;
        a_sh_q <= a_i;
        cnt_q  <= CNTW'(ITER);
      end else if (cnt_q != '0) begin
        acc_q  <= sum_n >> 1;
        a_sh_q <= a_sh_q >> 1;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign p_o    = acc_q[OW-1:0];
endmodule

// File: rtl/mont_exp_fsub.sv
// Single deferred reduction: input below 2m, output below m.
module mont_exp_fsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   p_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] r_o
);
  logic [WIDTH:0] diff;

  always_comb begin
    diff = p_i - {1'b0, m_i};
    r_o  = (p_i >= {1'b0, m_i}) ? diff[WIDTH-1:0] : p_i[WIDTH-1:0];
  end
endmodule

// File: rtl/mont_exp.sv
module mont_exp
  import mont_exp_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int EXP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic [EXP_W-1:0] e_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic [WIDTH-1:0] r2_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int OW   = WIDTH + 1;
  localparam int ITER = WIDTH + 2;   // R = 2^ITER
  localparam int CW   = $clog2(EXP_W + 1);

  logic [OW-1:0]    b_q, p_q, z_q;
  logic [WIDTH-1:0] m_q, res_q, sub_r;
  logic [EXP_W-1:0] e_q;
  logic [CW-1:0]    bits_q;
  phase_e           phase_q;
  logic             busy_q, go_q, done_q;
  logic             sq_done, pz_done;
  logic [OW-1:0]    sq_p, pz_p;

  // squaring: A = Z, B = shared B
  mont_mul_serial #(.OW(OW), .ITER(ITER)) u_mul_sq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_q),
    .a_i(z_q), .b_i(b_q), .n_i({1'b0, m_q}),
    .done_o(sq_done), .p_o(sq_p)
  );

  // product: A = P, B = shared B
  mont_mul_serial #(.OW(OW), .ITER(ITER)) u_mul_pz (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_q),
    .a_i(p_q), .b_i(b_q), .n_i({1'b0, m_q}),
    .done_o(pz_done), .p_o(pz_p)
  );

  mont_exp_fsub #(.WIDTH(WIDTH)) u_fsub (
    .p_i(p_q), .m_i(m_q), .r_o(sub_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q     <= '0;
      p_q     <= '0;
      z_q     <= '0;
      m_q     <= '0;
      e_q     <= '0;
      bits_q  <= '0;
      res_q   <= '0;
      phase_q <= PH_PRE;
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          b_q     <= {1'b0, r2_i};
          p_q     <= OW'(1);
          z_q     <= {1'b0, x_i};
          m_q     <= m_i;
          e_q     <= e_i;
          bits_q  <= CW'(EXP_W);
          phase_q <= PH_PRE;
          busy_q  <= 1'b1;
          go_q    <= 1'b1;
        end
      end else if (phase_q == PH_SUB) begin
        res_q   <= sub_r;
        done_q  <= 1'b1;
        busy_q  <= 1'b0;
        phase_q <= PH_PRE;
      end else if (sq_done) begin
        unique case (phase_q)
          PH_PRE: begin
            z_q  <= sq_p;
            p_q  <= pz_p;
            go_q <= 1'b1;
            if (bits_q == '0) begin
              b_q     <= OW'(1);
              phase_q <= PH_POST;
            end else begin
              b_q     <= sq_p;
              phase_q <= PH_BIT;
            end
          end
          PH_BIT: begin
            z_q    <= sq_p;
            if (e_q[0]) p_q <= pz_p;
            e_q    <= e_q >> 1;
            bits_q <= bits_q - 1'b1;
            go_q   <= 1'b1;
            if (bits_q == CW'(1)) begin
              b_q     <= OW'(1);
              phase_q <= PH_POST;
            end else begin
              b_q <= sq_p;
            end
          end
          PH_POST: begin
            p_q     <= pz_p;
            phase_q <= PH_SUB;
          end
          default: phase_q <= PH_PRE;
        endcase
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/mont_exp_chk.sv
module mont_exp_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o,
  input logic [WIDTH-1:0] m_q,
  input logic             sq_done,
  input logic [WIDTH:0]   sq_p
);
  a_r5_result_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o < m_q));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r7_mod_kept_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> $stable(m_q));

  a_r8_result_held_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(result_o));

  // R2: deferred reduction keeps every product below 2m
  a_r2_product_below_2m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_done |-> (sq_p < {m_q, 1'b0}));
endmodule

bind mont_exp mont_exp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o), .m_q(m_q),
  .sq_done(sq_done), .sq_p(sq_p)
);

// File: tb/tb_mont_exp.sv
`timescale 1ns/1ps
module tb_mont_exp;
  localparam int WIDTH = 8;
  localparam int EXP_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [WIDTH-1:0] x_i = '0, m_i = '0, r2_i = '0;
  logic [EXP_W-1:0] e_i = '0;
  logic             busy_o, done_o;
  logic [WIDTH-1:0] result_o;

  int checks = 0;
  int errors = 0;
  int lat_ref = -1;
  int cycles = 0;
  int seed = 12345;

  always #2 clk = ~clk;  // 250 MHz

  mont_exp #(.WIDTH(WIDTH), .EXP_W(EXP_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .x_i(x_i), .e_i(e_i),
    .m_i(m_i), .r2_i(r2_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_pow(input longint x, input longint e, input longint m);
    longint r = 1 % m;
    longint b = x % m;
    for (int i = 0; i < EXP_W; i++) begin
      if (e[i]) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r;
  endfunction

  function automatic longint ref_r2(input longint m);
    return (longint'(1) << (2 * (WIDTH + 2))) % m;
  endfunction

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  // glitch_at > 0: pulse start with other operands that many cycles into the run (R7)
  task automatic run_exp(input int x, input int e, input int m, input int glitch_at,
                         output int res);
    int lat;
    @(negedge clk);
    x_i = x[WIDTH-1:0]; e_i = e[EXP_W-1:0]; m_i = m[WIDTH-1:0];
    r2_i = ref_r2(m)[WIDTH-1:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    chk(busy_o === 1'b1, "R6 busy after start", busy_o, 1);
    while (done_o !== 1'b1 && lat < 3000) begin
      if (glitch_at > 0 && lat == glitch_at) begin
        x_i = 8'd2; e_i = 8'd3; m_i = 8'd251; r2_i = ref_r2(251)[WIDTH-1:0];
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
      if (done_o !== 1'b1) chk(busy_o === 1'b1, "R6 busy held", busy_o, 1);
    end
    start_i = 1'b0;
    chk(done_o === 1'b1, "R6 done timeout", lat, 0);
    res = int'(result_o);
    chk(busy_o === 1'b0, "R6 busy clear at done", busy_o, 0);
    if (lat_ref < 0) lat_ref = lat;
    else chk(lat == lat_ref, "R9 fixed latency", lat, lat_ref);
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done one cycle", done_o, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 195000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int res;
    int hold;
    #1;
    chk(busy_o === 1'b0, "R1 busy reset", busy_o, 0);
    chk(done_o === 1'b0, "R1 done reset", done_o, 0);
    chk(result_o === '0, "R1 result reset", result_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int m = 3; m < 256; m += 2) begin
      run_exp(0, 0, m, 0, res);
      chk(res == 1, "R3 zero exponent", res, 1);
      run_exp(m - 1, 1, m, 0, res);
      chk(res == m - 1, "R4 unit exponent", res, m - 1);
      run_exp(0, 5, m, 0, res);
      chk(res == 0, "R2 zero base", res, 0);
      run_exp(m - 1, 255, m, 0, res);
      chk(res == ref_pow(m - 1, 255, m), "R2 full exponent", res, ref_pow(m - 1, 255, m));
      for (int k = 0; k < 2; k++) begin
        int x = next_rand() % m;
        int e = next_rand() % 256;
        run_exp(x, e, m, 0, res);
        chk(res == ref_pow(x, e, m), "R2 random", res, ref_pow(x, e, m));
        chk(res < m, "R5 below modulus", res, m);
      end
    end

    // R7: start pulse in mid-run ignored
    run_exp(77, 201, 239, 20, res);
    chk(res == ref_pow(77, 201, 239), "R7 start while busy", res, ref_pow(77, 201, 239));

    // R8: result held while idle with changing inputs
    hold = res;
    x_i = 8'd5; e_i = 8'd9; m_i = 8'd13;
    repeat (6) @(negedge clk);
    chk(int'(result_o) == hold, "R8 result held", result_o, hold);
    chk(busy_o === 1'b0, "R8 stays idle", busy_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule